// File: doc/BRIEF.md
# Partitioned Low-Power Scan Shift Controller

This block drives the scan cells of a core whose flip-flops are split into two halves. Both halves use one base clock and are controlled through clock enables. During a shift burst the halves take turns. The first cycle goes to the even half, the next to the odd half, and so on. Each half therefore moves at half the base rate, yet the serial port still takes one bit on every cycle. Bits entering on the serial input are steered alternately into the heads of the two half chains. The serial output is taken from the two tails in the same alternating order. Seen from outside, the two halves behave as one interleaved chain of twice the half length.

A freeze input stops the odd half completely: it neither shifts nor captures while freeze is high. While scan enable is high, the values the cells drive into the logic under test are held at the contents left by the last non-shift edge. With scan enable low the cell values pass straight through. A toggle count output reports how many cells will change at the coming edge, so switching can be measured.

Top module: `lps_scan_ctrl`

## Requirements
- R1: After reset every scan cell is 0, `logic_q` is all zeros, `scan_out` is 0 and the first shift slot belongs to the even half.
- R2: Interleaved position 2k is even-half cell k and position 2k+1 is odd-half cell k. With freeze low, a burst of 2*HALF_LEN shift cycles behaves like one full-rate chain. On each cycle `scan_out` shows position 0, then every position takes the value from the position above it, and position 2*HALF_LEN-1 takes `scan_in`.
- R3: The first shift cycle after `scan_en` rises serves the even half, and later cycles alternate strictly between the halves. At most one half moves per cycle. `scan_out` shows the tail of the half that owns the current slot.
- R4: On every edge with `scan_en` low, each unfrozen cell loads `func_d` at its interleaved position.
- R5: While `freeze_b` is high, odd positions keep their contents on both shift and capture edges. In a frozen burst, even slots shift only the even positions, odd slots drop `scan_in`, and `scan_out` shows the unchanged odd tail (position 1) on odd slots.
- R6: While `scan_en` is high, `logic_q` equals the cell contents left by the last edge at which `scan_en` was low. While `scan_en` is low, `logic_q` equals the current cell contents.
- R7: `toggle_cnt` equals the number of scan cells whose value differs between now and after the coming edge.
- R8: During shift no more than HALF_LEN cells change per cycle. For a pattern alternating 1,0,… loaded over an all-ones chain, fewer cells change than in a single full-rate chain of the same length.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Base clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| scan_en | input | 1 | High: shift; low: capture |
| freeze_b | input | 1 | High: odd half neither shifts nor captures |
| scan_in | input | 1 | Serial test data in |
| func_d | input | 2*HALF_LEN | Response of the logic under test, by interleaved position |
| scan_out | output | 1 | Serial test data out |
| logic_q | output | 2*HALF_LEN | Cell values presented to the logic under test, held during shift |
| toggle_cnt | output | $clog2(2*HALF_LEN+1) | Cells that will change at the next edge |

## Verification
If the phase bit starts on the wrong half or stops alternating, the serial output stream misorders bits. This shows up within the first two cycles of an unload, when positions 0 and 1 come out swapped. A leak through the freeze gating alters odd positions, which shows up on the next unload after a frozen capture or a frozen shift. A hold register loaded at the wrong moment shows up on `logic_q` during the very first cycle of the following shift burst. A miscounted toggle figure differs from the expected count on the same cycle.

// File: rtl/lps_pkg.sv
package lps_pkg;

  typedef enum logic {
    PH_EVEN = 1'b0,
    PH_ODD  = 1'b1
  } phase_e;

  typedef struct packed {
    logic sh_even;
    logic sh_odd;
    logic cap_even;
    logic cap_odd;
  } half_en_t;

  // Slot owner for the next cycle: restart on the even half whenever
  // shifting stops, otherwise swap halves.
  function automatic phase_e phase_next(phase_e cur, logic shifting);
    if (!shifting) return PH_EVEN;
    return (cur == PH_EVEN) ? PH_ODD : PH_EVEN;
  endfunction

  // Per-half enables for the current cycle.
  function automatic half_en_t steer(phase_e cur, logic shifting, logic frz);
    half_en_t e;
    e.sh_even  = shifting && (cur == PH_EVEN);
    e.sh_odd   = shifting && (cur == PH_ODD) && !frz;
    e.cap_even = !shifting;
    e.cap_odd  = !shifting && !frz;
    return e;
  endfunction

endpackage

// File: rtl/lps_phase_ctrl.sv
module lps_phase_ctrl
  import lps_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     scan_en,
  input  logic     freeze_b,
  output phase_e   phase_q,
  output half_en_t en
);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) phase_q <= PH_EVEN;
    else        phase_q <= phase_next(phase_q, scan_en);
  end

  always_comb en = steer(phase_q, scan_en, freeze_b);

  // R3: a burst always opens on the even half
  p_burst_start_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(scan_en) |-> (phase_q == PH_EVEN));

  // R3: consecutive shift cycles swap owners
  p_phase_swap_r3: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> (!scan_en || (phase_q != $past(phase_q))));

endmodule

// File: rtl/lps_half_chain.sv
module lps_half_chain #(
  parameter int LEN = 8
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           sh_en,
  input  logic           cap_en,
  input  logic           si,
  input  logic [LEN-1:0] cap_d,
  output logic [LEN-1:0] q,
  output logic [LEN-1:0] q_nxt,
  output logic           so
);

  // Head at index LEN-1, tail at index 0.
  always_comb begin
    if (sh_en)       q_nxt = {si, q[LEN-1:1]};
    else if (cap_en) q_nxt = cap_d;
    else             q_nxt = q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) q <= '0;
    else        q <= q_nxt;
  end

  assign so = q[0];

  // R5: a half with neither enable keeps its contents
  p_idle_keeps_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (!sh_en && !cap_en) |=> $stable(q));

  // R2: a shift puts the serial bit at the head and moves the head down
  p_head_loads_r2: assert property (@(posedge clk) disable iff (!rst_n)
    sh_en |=> ((q[LEN-1] == $past(si)) && (q[LEN-2] == $past(q[LEN-1]))));

endmodule

// File: rtl/lps_hold_gate.sv
module lps_hold_gate #(
  parameter int W = 16
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         scan_en,
  input  logic [W-1:0] live_q,
  input  logic [W-1:0] live_nxt,
  output logic [W-1:0] logic_q
);

  logic [W-1:0] hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        hold_q <= '0;
    else if (!scan_en) hold_q <= live_nxt;
  end

  assign logic_q = scan_en ? hold_q : live_q;

  // R6: logic inputs stay put across shift cycles
  p_hold_steady_r6: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |=> (!scan_en || $stable(logic_q)));

  // R6: first shift cycle presents what the last non-shift edge left behind
  p_hold_source_r6: assert property (@(posedge clk) disable iff (!rst_n)
    !scan_en |=> (!scan_en || (logic_q == $past(live_nxt))));

endmodule

// File: rtl/lps_toggle_meter.sv
module lps_toggle_meter #(
  parameter int W  = 16,
  parameter int CW = 5
) (
  input  logic [W-1:0]  cur,
  input  logic [W-1:0]  nxt,
  output logic [CW-1:0] cnt
);

  logic [W-1:0] diff;

  assign diff = cur ^ nxt;
  assign cnt  = CW'($countones(diff));

endmodule

// File: rtl/lps_scan_ctrl.sv
module lps_scan_ctrl
  import lps_pkg::*;
#(
  parameter int HALF_LEN = 8,
  localparam int TOTAL   = 2 * HALF_LEN,
  localparam int CNT_W   = $clog2(TOTAL + 1)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             scan_en,
  input  logic             freeze_b,
  input  logic             scan_in,
  input  logic [TOTAL-1:0] func_d,
  output logic             scan_out,
  output logic [TOTAL-1:0] logic_q,
  output logic [CNT_W-1:0] toggle_cnt
);

  phase_e   phase_q;
  half_en_t en;

  logic [HALF_LEN-1:0] even_q, even_nxt, even_cap;
  logic [HALF_LEN-1:0] odd_q,  odd_nxt,  odd_cap;
  logic                even_so, odd_so;
  logic [TOTAL-1:0]    cells_q, cells_nxt;

  lps_phase_ctrl u_phase (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_en  (scan_en),
    .freeze_b (freeze_b),
    .phase_q  (phase_q),
    .en       (en)
  );

  // Interleaved view: position 2k -> even half, 2k+1 -> odd half.
  for (genvar k = 0; k < HALF_LEN; k++) begin : g_weave
    assign even_cap[k]      = func_d[2*k];
    assign odd_cap[k]       = func_d[2*k+1];
    assign cells_q[2*k]     = even_q[k];
    assign cells_q[2*k+1]   = odd_q[k];
    assign cells_nxt[2*k]   = even_nxt[k];
    assign cells_nxt[2*k+1] = odd_nxt[k];
  end

  lps_half_chain #(.LEN(HALF_LEN)) u_even (
    .clk    (clk),
    .rst_n  (rst_n),
    .sh_en  (en.sh_even),
    .cap_en (en.cap_even),
    .si     (scan_in),
    .cap_d  (even_cap),
    .q      (even_q),
    .q_nxt  (even_nxt),
    .so     (even_so)
  );

  lps_half_chain #(.LEN(HALF_LEN)) u_odd (
    .clk    (clk),
    .rst_n  (rst_n),
    .sh_en  (en.sh_odd),
    .cap_en (en.cap_odd),
    .si     (scan_in),
    .cap_d  (odd_cap),
    .q      (odd_q),
    .q_nxt  (odd_nxt),
    .so     (odd_so)
  );

  assign scan_out = (phase_q == PH_ODD) ? odd_so : even_so;

  lps_hold_gate #(.W(TOTAL)) u_hold (
    .clk      (clk),
    .rst_n    (rst_n),
    .scan_en  (scan_en),
    .live_q   (cells_q),
    .live_nxt (cells_nxt),
    .logic_q  (logic_q)
  );

  lps_toggle_meter #(.W(TOTAL), .CW(CNT_W)) u_meter (
    .cur (cells_q),
    .nxt (cells_nxt),
    .cnt (toggle_cnt)
  );

  // R5: frozen odd half does not move on that edge
  p_freeze_odd_r5: assert property (@(posedge clk) disable iff (!rst_n)
    freeze_b |=> $stable(odd_q));

  // R8: only one half switches per shift cycle
  p_half_switch_r8: assert property (@(posedge clk) disable iff (!rst_n)
    scan_en |-> (toggle_cnt <= CNT_W'(HALF_LEN)));

  // R4: unfrozen capture loads every position
  p_capture_all_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!scan_en && !freeze_b) |=> (cells_q == $past(func_d)));

endmodule

// File: tb/test_lps_scan_ctrl.sv
module test_lps_scan_ctrl;
  localparam int HL = 8;
  localparam int N  = 2 * HL;
  localparam int CW = $clog2(N + 1);

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          scan_en = 1'b0;
  logic          freeze_b = 1'b0;
  logic          scan_in = 1'b0;
  logic [N-1:0]  func_d = '0;
  logic          scan_out;
  logic [N-1:0]  logic_q;
  logic [CW-1:0] toggle_cnt;

  always #10 clk = ~clk;

  lps_scan_ctrl #(.HALF_LEN(HL)) i_lps_scan_ctrl (
    .clk        (clk),
    .rst_n      (rst_n),
    .scan_en    (scan_en),
    .freeze_b   (freeze_b),
    .scan_in    (scan_in),
    .func_d     (func_d),
    .scan_out   (scan_out),
    .logic_q    (logic_q),
    .toggle_cnt (toggle_cnt)
  );

  typedef struct {
    bit           chk_so;
    bit           so;
    bit           chk_lq;
    logic [N-1:0] lq;
    bit           chk_tog;
    int           tog;
    bit           acc;
    string        req;
  } item_t;

  item_t        sb[$];
  int           n_cmp = 0;
  int           n_bad = 0;
  int           dut_sum = 0;
  int           ref_sum = 0;
  logic [N-1:0] ref_q = '0;  // interleaved chain as the requirements define it
  logic [N-1:0] held  = '0;  // what logic_q must show during shift

  task automatic check(input string req, input string what,
                       input logic [63:0] got, input logic [63:0] exp);
    n_cmp++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
    end
  endtask

  // Monitor: one item per driven cycle, compared mid-cycle.
  always @(negedge clk) begin
    item_t it;
    if (sb.size() > 0) begin
      it = sb.pop_front();
      if (it.chk_so)  check(it.req, "scan_out",   64'(scan_out),   64'(it.so));
      if (it.chk_lq)  check(it.req, "logic_q",    64'(logic_q),    64'(it.lq));
      if (it.chk_tog) check(it.req, "toggle_cnt", 64'(toggle_cnt), 64'(it.tog));
      if (it.acc) dut_sum += int'(toggle_cnt);
    end
  end

  task automatic step();
    @(posedge clk);
    #2;
  endtask

  function automatic logic [N-1:0] rnd_vec();
    logic [N-1:0] v;
    for (int b = 0; b < N; b++) v[b] = 1'($urandom_range(0, 1));
    return v;
  endfunction

  // Driver: one shift burst of N cycles, bit j of pat entering on cycle j.
  task automatic shift_pat(input logic [N-1:0] pat, input bit frz,
                           input bit tog_one, input bit acc);
    for (int j = 0; j < N; j++) begin
      item_t        it;
      logic [N-1:0] nx;
      step();
      scan_en  = 1'b1;
      freeze_b = frz;
      scan_in  = pat[j];
      it.chk_so  = 1'b1;
      it.chk_lq  = 1'b1;
      it.lq      = held;         // R6
      it.chk_tog = tog_one;      // R7
      it.tog     = 1;
      it.acc     = acc;
      if (!frz) begin            // R2, R3: full-rate chain view
        it.req = "R2,R3,R6,R7";
        it.so  = ref_q[0];
        nx     = {pat[j], ref_q[N-1:1]};
      end else begin             // R5: odd positions frozen
        it.req = "R5,R6";
        it.so  = (j % 2 == 0) ? ref_q[0] : ref_q[1];
        nx     = ref_q;
        if (j % 2 == 0) begin
          for (int k = 0; k < HL - 1; k++) nx[2*k] = ref_q[2*k+2];
          nx[N-2] = pat[j];
        end
      end
      ref_sum += $countones(nx ^ ref_q);
      ref_q = nx;
      sb.push_back(it);
    end
  endtask

  // Driver: one capture cycle.
  task automatic capture(input logic [N-1:0] f, input bit frz);
    item_t        it;
    logic [N-1:0] nx;
    step();
    scan_en  = 1'b0;
    freeze_b = frz;
    func_d   = f;
    nx = f;
    if (frz) for (int k = 0; k < HL; k++) nx[2*k+1] = ref_q[2*k+1];  // R5
    it.req     = frz ? "R4,R5,R6,R7" : "R4,R6,R7";
    it.chk_so  = 1'b1;
    it.so      = ref_q[0];
    it.chk_lq  = 1'b1;
    it.lq      = ref_q;          // pass-through of current cells
    it.chk_tog = 1'b1;
    it.tog     = $countones(nx ^ ref_q);
    it.acc     = 1'b0;
    sb.push_back(it);
    ref_q = nx;
    held  = nx;
  endtask

  initial begin
    #(20 * 100000);
    n_cmp++;
    n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin
    logic [N-1:0] alt;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1", "scan_out",   64'(scan_out),   64'd0);
    check("R1", "logic_q",    64'(logic_q),    64'd0);
    check("R1", "toggle_cnt", 64'(toggle_cnt), 64'd0);

    // R7: ones shifted into a cleared chain change exactly one cell per cycle
    shift_pat('1, 1'b0, 1'b1, 1'b0);
    capture(rnd_vec(), 1'b0);
    shift_pat(rnd_vec(), 1'b0, 1'b0, 1'b0);
    capture(rnd_vec(), 1'b0);
    shift_pat(rnd_vec(), 1'b0, 1'b0, 1'b0);
    // R5: frozen capture, then unload
    capture(rnd_vec(), 1'b1);
    shift_pat(rnd_vec(), 1'b0, 1'b0, 1'b0);
    capture(rnd_vec(), 1'b0);
    // R5: frozen shift, frozen capture, then unload
    shift_pat(rnd_vec(), 1'b1, 1'b0, 1'b0);
    capture(rnd_vec(), 1'b1);
    shift_pat(rnd_vec(), 1'b0, 1'b0, 1'b0);

    // R8: alternating pattern over an all-ones chain
    capture('1, 1'b0);
    for (int b = 0; b < N; b++) alt[b] = (b % 2 == 0);
    step();
    ref_sum = 0;
    dut_sum = 0;
    // the step above is a capture cycle on all ones; keep model in step
    sb.push_back('{chk_so: 1'b0, so: 1'b0, chk_lq: 1'b0, lq: '0,
                   chk_tog: 1'b0, tog: 0, acc: 1'b0, req: "R8"});
    shift_pat(alt, 1'b0, 1'b0, 1'b1);
    capture('0, 1'b0);
    step();
    step();
    check("R7", "toggle sum over alternating burst", 64'(dut_sum), 64'(HL));
    check("R8", "fewer toggles than full chain", 64'(dut_sum < ref_sum), 64'd1);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

endmodule